// File: doc/BRIEF.md
# Chip-Select Command Filter with Configuration Register

This block sits behind the serial front end of a secure memory device. It decides, from the first byte of each command, whether that command is meant for this device. The upper nibble of the byte is the chip-select address. A command is taken when that nibble equals the fixed global address 4'hB. It is also taken when the nibble equals the per-device address held in the low nibble of an 8-bit configuration register. Up to fifteen devices can then share one bus and still be reached one at a time. Address 4'hB always reaches every device at once.

The configuration register is active low and resets to 8'hFF. Its layout, from bit 7 down to bit 0, is:

- bit 7: supervisor enable
- bit 6: unlimited checksum reads
- bit 5: unlimited trials
- bit 4: eight trials
- bits 3:0: the programmable address

The block drives each of these fields on its own outputs for the logic that uses them.

The block also applies the one-shot checksum policy. While bit 6 is 1, each completed checksum read raises a one-cycle crypto-reset pulse. While bit 6 is 0, checksum reads are unlimited and no pulse is raised.

Top module: `cs_cmd_filter`

## Requirements
- R1: While reset is held, and after its release, the register reads 8'hFF and `cmd_accept`, `cmd_bcast` and `crypto_rst` are 0.
- R2: A write with `cfg_we`=1 at a rising edge loads `cfg_wdata`. The field outputs show the new value from that edge on: `cfg_supv_n`=bit7, `cfg_csum_lim`=bit6, `cfg_trial_unl_n`=bit5, `cfg_eight_n`=bit4, `cfg_addr`=bits3:0.
- R3: A valid command whose bits 7:4 are 4'hB raises `cmd_accept` and `cmd_bcast` together, for one cycle, in the cycle after the byte.
- R4: A valid command whose bits 7:4 equal `cfg_addr` (other than 4'hB) raises `cmd_accept` with `cmd_bcast`=0, one cycle after the byte.
- R5: A valid command that matches neither address produces no `cmd_accept` and no `cmd_bcast`.
- R6: With `cmd_valid`=0 the byte value is ignored, and `cmd_accept` and `cmd_bcast` stay 0.
- R7: `csum_done` while bit 6 is 1 produces `crypto_rst`=1 for exactly the next cycle.
- R8: `csum_done` while bit 6 is 0 produces no `crypto_rst`.
- R9: A command presented in the same cycle as a register write is compared against the address held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | First command byte present this cycle |
| cmd_byte | input | 8 | First command byte; bits 7:4 are the address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value |
| csum_done | input | 1 | A checksum read has completed |
| cmd_accept | output | 1 | Command addressed to this device |
| cmd_bcast | output | 1 | Accepted command used the global address |
| cfg_supv_n | output | 1 | Register bit 7, supervisor enable (active low) |
| cfg_csum_lim | output | 1 | Register bit 6; 1 limits checksum reads to one |
| cfg_trial_unl_n | output | 1 | Register bit 5, unlimited trials (active low) |
| cfg_eight_n | output | 1 | Register bit 4, eight trials (active low) |
| cfg_addr | output | 4 | Register bits 3:0, programmable address |
| crypto_rst | output | 1 | One-cycle crypto reset request |

## Verification
A corrupted address nibble shows as accepts on the wrong command bytes, and as missed accepts on the right ones. It appears on the first command after the bad write, and also at once on `cfg_addr`. A wrong bit 6 shows on the next checksum completion: the crypto-reset pulse is either missing or present when it should not be. A register that takes a write one cycle late shows when a command arrives just after a write. A register that applies a write too early shows when a command and a write arrive in the same cycle. Either fault appears as a single wrong accept.

// File: rtl/cs_cmd_filter.sv
module cs_cmd_filter #(
  parameter logic [3:0] GLOBAL_ADDR = 4'hB,
  parameter logic [7:0] CFG_RESET   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       csum_done,
  output logic       cmd_accept,
  output logic       cmd_bcast,
  output logic       cfg_supv_n,
  output logic       cfg_csum_lim,
  output logic       cfg_trial_unl_n,
  output logic       cfg_eight_n,
  output logic [3:0] cfg_addr,
  output logic       crypto_rst
);

  logic [7:0] cfg;
  logic [3:0] sel;
  logic       hit_global, hit_own;

  assign sel        = cmd_byte[7:4];
  assign hit_global = sel == GLOBAL_ADDR;
  assign hit_own    = sel == cfg[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= CFG_RESET;
    else if (cfg_we) cfg <= cfg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_accept <= 1'b0;
      cmd_bcast  <= 1'b0;
      crypto_rst <= 1'b0;
    end else begin
      cmd_accept <= cmd_valid && (hit_global || hit_own);
      cmd_bcast  <= cmd_valid && hit_global;
      crypto_rst <= csum_done && cfg[6];
    end

  assign cfg_supv_n      = cfg[7];
  assign cfg_csum_lim    = cfg[6];
  assign cfg_trial_unl_n = cfg[5];
  assign cfg_eight_n     = cfg[4];
  assign cfg_addr        = cfg[3:0];

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> {cfg_supv_n, cfg_csum_lim, cfg_trial_unl_n, cfg_eight_n, cfg_addr} == $past(cfg_wdata));

  assert_bcast_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bcast |-> cmd_accept);

  assert_accept_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> $past(cmd_valid) &&
      ($past(cmd_byte[7:4]) == GLOBAL_ADDR || $past(cmd_byte[7:4]) == $past(cfg_addr)));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> !cmd_accept && !cmd_bcast);

  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crypto_rst |-> $past(csum_done) && $past(cfg_csum_lim));

  assert_no_rst_unlimited_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csum_done) && !$past(cfg_csum_lim) |-> !crypto_rst);

endmodule

// File: tb/tb_cs_cmd_filter.sv
module tb_cs_cmd_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cfg_we = 1'b0, csum_done = 1'b0;
  logic [7:0] cmd_byte = 8'h00, cfg_wdata = 8'h00;
  logic cmd_accept, cmd_bcast, cfg_supv_n, cfg_csum_lim, cfg_trial_unl_n, cfg_eight_n, crypto_rst;
  logic [3:0] cfg_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_cmd_filter dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .csum_done(csum_done),
    .cmd_accept(cmd_accept), .cmd_bcast(cmd_bcast), .cfg_supv_n(cfg_supv_n),
    .cfg_csum_lim(cfg_csum_lim), .cfg_trial_unl_n(cfg_trial_unl_n),
    .cfg_eight_n(cfg_eight_n), .cfg_addr(cfg_addr), .crypto_rst(crypto_rst)
  );

  typedef struct {
    logic       acc;
    logic       bc;
    logic       rst;
    logic [7:0] cfg;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic [7:0] model_cfg = 8'hFF;
  bit done = 0;

  function automatic logic [7:0] obs_cfg();
    return {cfg_supv_n, cfg_csum_lim, cfg_trial_unl_n, cfg_eight_n, cfg_addr};
  endfunction

  task automatic step(input logic v, input logic [7:0] b, input logic we,
                      input logic [7:0] wd, input logic cs, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = v; cmd_byte = b; cfg_we = we; cfg_wdata = wd; csum_done = cs;
    e.bc  = v && (b[7:4] == 4'hB);
    e.acc = v && (b[7:4] == 4'hB || b[7:4] == model_cfg[3:0]);
    e.rst = cs && model_cfg[6];
    if (we) model_cfg = wd;
    e.cfg = model_cfg;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cmd_accept !== e.acc || cmd_bcast !== e.bc || crypto_rst !== e.rst || obs_cfg() !== e.cfg) begin
          failures++;
          $display("FAIL %s: acc=%b bc=%b rst=%b cfg=%h expected acc=%b bc=%b rst=%b cfg=%h",
                   e.tag, cmd_accept, cmd_bcast, crypto_rst, obs_cfg(), e.acc, e.bc, e.rst, e.cfg);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (obs_cfg() !== 8'hFF || cmd_accept !== 1'b0 || cmd_bcast !== 1'b0 || crypto_rst !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: cfg=%h acc=%b bc=%b rst=%b expected cfg=ff acc=0 bc=0 rst=0",
               obs_cfg(), cmd_accept, cmd_bcast, crypto_rst);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 8'h00, 0, 8'h00, 0, "R1 after release");
    step(1, 8'hB3, 0, 8'h00, 0, "R3 global address");
    step(1, 8'hF1, 0, 8'h00, 0, "R4 default own address F");
    step(1, 8'h30, 0, 8'h00, 0, "R5 no match");
    step(0, 8'hB0, 0, 8'h00, 0, "R6 byte without valid");
    step(0, 8'h00, 1, 8'h45, 0, "R2 write 45");
    step(1, 8'h5A, 0, 8'h00, 0, "R4 own address 5");
    step(1, 8'hF0, 0, 8'h00, 0, "R5 old address F no longer matches");
    step(1, 8'hB9, 0, 8'h00, 0, "R3 global after write");
    step(0, 8'h00, 0, 8'h00, 1, "R7 checksum pulse");
    step(0, 8'h00, 0, 8'h00, 0, "R7 pulse is single cycle");
    step(0, 8'h00, 1, 8'h05, 0, "R2 write 05");
    step(0, 8'h00, 0, 8'h00, 1, "R8 unlimited checksum no pulse");
    step(1, 8'h70, 1, 8'hA7, 0, "R9 same-cycle write uses old address");
    step(1, 8'h71, 0, 8'h00, 0, "R9 new address 7 after write");
    step(1, 8'h52, 0, 8'h00, 0, "R5 address 5 dropped");
    step(0, 8'h00, 1, 8'h3B, 0, "R2 write 3B");
    step(1, 8'hB4, 1, 8'h00, 0, "R3 own equals global");
    step(0, 8'h00, 0, 8'h00, 1, "R8 bit6 zero no pulse");
    step(1, 8'h0C, 0, 8'h00, 0, "R4 own address 0");
    step(0, 8'h00, 1, 8'h40, 1, "R7 pulse uses bit6 before write");
    step(0, 8'h00, 0, 8'h00, 1, "R7 pulse after bit6 set");
    step(0, 8'h00, 0, 8'h00, 0, "R6 idle");
    @(negedge clk);
    cmd_valid = 0; cfg_we = 0; csum_done = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule